// File: doc/BRIEF.md
# Flash Embedded Erase Sequencer

This block is the self-timed erase engine of a small NOR flash array, together with a behavioural model of that array. The host gives a single start pulse with a sector mask, or a whole-device flag. The engine then works with no further host help. First it programs every word of the chosen sectors to zero and checks that each word reads back as zero. Only then does it apply erase pulses, each followed by a verify sweep. It stops by itself once every chosen word reads all ones.

While the engine runs, every read returns a status word instead of array data. The completion bit sits in bit 7 and again in bit 15. The active-low ready/busy line `busy_no` stays low for the whole operation. A one-cycle `done_o` marks normal completion. An abort input models the reset command: it stops the engine at once and marks the targeted sectors invalid. Reads from an invalid sector return a fixed flag pattern with `rd_bad_o` set, until a later erase of that sector completes.

All latencies are parameters counted in clock cycles: program per word, verify per word, erase pulse length, and the number of pulses needed to reach margin. The array has one host program port. A host write can only clear bits.

Top module: `flash_erase_seq`

## Requirements
- R1: When idle, a start pulse with a non-empty sector mask (or with chip_i high) drives busy_no low from the next cycle. A start with an empty mask and chip_i low is ignored. A start while busy is ignored.
- R2: During the pre-program and zero-verify sweeps, status bits 6 and 14 read 0. During the erase-pulse and erase-verify part, they read 1. The switch happens after exactly N*(PGM_CYC+VFY_CYC) busy cycles, where N is the number of selected words.
- R3: With no abort, busy_no stays low for exactly N*PGM_CYC + 2*N*VFY_CYC + ERS_PULSES*ERS_CYC + (ERS_PULSES-1)*VFY_CYC cycles. A failed erase verify stops at the first word.
- R4: While busy, a read at any address returns a status word with bit 7 = 0 and bit 15 = 0, and rd_bad_o = 0.
- R5: After completion, every word of the selected sectors reads 16'hFFFF, so bit 7 reads 1. Words of other sectors keep their contents.
- R6: done_o pulses for exactly one cycle, in the same cycle that busy_no returns high after a normal completion.
- R7: abort_i while busy returns busy_no high on the next cycle with no done_o pulse. Afterwards, reads in the targeted sectors return INV_PAT (default 16'hA5A5) with rd_bad_o = 1. Other sectors read normally with rd_bad_o = 0.
- R8: A later erase that completes on an invalid sector clears its invalid flag, and that sector then reads all ones.
- R9: A host write stores old AND data, so it can only clear bits. A host write while busy is ignored.
- R10: chip_i selects every sector regardless of the mask.
- R11: abort_i while idle has no effect on busy_no or on read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; the array powers up all ones |
| start_i | input | 1 | Start erase (sampled when idle) |
| sec_mask_i | input | NUM_SECTORS | Sectors to erase |
| chip_i | input | 1 | Erase the whole device |
| abort_i | input | 1 | Reset command: stop the running erase |
| wr_en_i | input | 1 | Host program strobe |
| wr_addr_i | input | AW | Host program address, {sector, word} |
| wr_data_i | input | DATA_W | Host program data (bits can only be cleared) |
| rd_addr_i | input | AW | Read address, {sector, word} |
| rd_data_o | output | DATA_W | Array data, status word, or invalid pattern |
| rd_bad_o | output | 1 | Read hit an invalidated sector |
| busy_no | output | 1 | Ready/busy, low while the algorithm runs |
| done_o | output | 1 | One-cycle pulse on normal completion |

## Verification
The checker assumes that start_i and abort_i are single-cycle pulses driven between clock edges. It also assumes that nothing else is driven in the same cycle as an abort. Its status-word checks assume DATA_W is 16. The bench keeps to these limits: it raises each control for exactly one edge from the falling edge, and it fires abort only mid-run or when idle, never together with start. It reads only at stable points half a cycle after the edge.

// File: rtl/fes_pkg.sv
package fes_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PGM,
    ST_PVFY,
    ST_ERS,
    ST_EVFY
  } fes_state_e;
endpackage

// File: rtl/fes_array.sv
module fes_array #(
  parameter int NUM_SECTORS  = 4,
  parameter int SECTOR_WORDS = 8,
  parameter int DATA_W       = 16,
  parameter int AW           = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   host_we_i,
  input  logic [AW-1:0]          host_addr_i,
  input  logic [DATA_W-1:0]      host_data_i,
  input  logic                   pgm_we_i,
  input  logic [AW-1:0]          pgm_addr_i,
  input  logic                   ers_i,
  input  logic [NUM_SECTORS-1:0] ers_mask_i,
  input  logic [AW-1:0]          rd_addr_i,
  output logic [DATA_W-1:0]      rd_data_o,
  input  logic [AW-1:0]          vfy_addr_i,
  output logic [DATA_W-1:0]      vfy_data_o
);
  localparam int WORDS = NUM_SECTORS * SECTOR_WORDS;

  logic [DATA_W-1:0] mem_q [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    localparam int SEC = i / SECTOR_WORDS;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[i] <= '1;
      end else if (ers_i && ers_mask_i[SEC]) begin
        mem_q[i] <= '1;
      end else if (pgm_we_i && pgm_addr_i == AW'(i)) begin
        mem_q[i] <= '0;
      end else if (host_we_i && host_addr_i == AW'(i)) begin
        // flash program can only clear bits
        mem_q[i] <= mem_q[i] & host_data_i;
      end
    end
  end

  assign rd_data_o  = mem_q[rd_addr_i];
  assign vfy_data_o = mem_q[vfy_addr_i];
endmodule

// File: rtl/fes_seq.sv
module fes_seq
  import fes_pkg::*;
#(
  parameter int NUM_SECTORS  = 4,
  parameter int SECTOR_WORDS = 8,
  parameter int DATA_W       = 16,
  parameter int PGM_CYC      = 3,
  parameter int VFY_CYC      = 2,
  parameter int ERS_CYC      = 5,
  parameter int ERS_PULSES   = 2,
  parameter int SEC_W        = 2,
  parameter int WRD_W        = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [NUM_SECTORS-1:0] sec_mask_i,
  input  logic                   chip_i,
  input  logic                   abort_i,
  output logic                   busy_no,
  output logic                   done_o,
  output logic                   erase_ph_o,
  output logic [NUM_SECTORS-1:0] bad_o,
  output logic                   pgm_we_o,
  output logic                   ers_o,
  output logic [NUM_SECTORS-1:0] op_mask_o,
  output logic [SEC_W+WRD_W-1:0] eng_addr_o,
  input  logic [DATA_W-1:0]      eng_data_i
);
  localparam int MAX_A  = (PGM_CYC > VFY_CYC) ? PGM_CYC : VFY_CYC;
  localparam int MAX_L  = (MAX_A > ERS_CYC) ? MAX_A : ERS_CYC;
  localparam int CNT_W  = $clog2(MAX_L + 1);
  localparam int PUL_W  = $clog2(ERS_PULSES + 1);
  localparam logic [WRD_W-1:0] LAST_WRD = WRD_W'(SECTOR_WORDS - 1);

  fes_state_e             state_q;
  logic [SEC_W-1:0]       sec_q;
  logic [WRD_W-1:0]       wrd_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [PUL_W-1:0]       pul_q;
  logic [NUM_SECTORS-1:0] op_mask_q, bad_q, sel;
  logic                   done_q;
  logic [SEC_W-1:0]       first_sec, start_sec, nxt_sec;
  logic                   has_nxt, step_end, last_wrd, at_end;

  function automatic logic [SEC_W-1:0] lowest(input logic [NUM_SECTORS-1:0] m);
    logic [SEC_W-1:0] r = '0;
    for (int s = NUM_SECTORS - 1; s >= 0; s--) if (m[s]) r = SEC_W'(s);
    return r;
  endfunction

  assign sel       = chip_i ? '1 : sec_mask_i;
  assign first_sec = lowest(op_mask_q);
  assign start_sec = lowest(sel);

  always_comb begin
    has_nxt = 1'b0;
    nxt_sec = '0;
    for (int s = NUM_SECTORS - 1; s >= 0; s--) begin
      if (op_mask_q[s] && s > int'(sec_q)) begin
        has_nxt = 1'b1;
        nxt_sec = SEC_W'(s);
      end
    end
  end

  assign step_end = (cnt_q == '0);
  assign last_wrd = (wrd_q == LAST_WRD);
  assign at_end   = last_wrd && !has_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      sec_q     <= '0;
      wrd_q     <= '0;
      cnt_q     <= '0;
      pul_q     <= '0;
      op_mask_q <= '0;
      bad_q     <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q != ST_IDLE && abort_i) begin
        state_q <= ST_IDLE;
        bad_q   <= bad_q | op_mask_q;
      end else begin
        unique case (state_q)
          ST_IDLE: if (start_i && |sel) begin
            op_mask_q <= sel;
            sec_q     <= start_sec;
            wrd_q     <= '0;
            cnt_q     <= CNT_W'(PGM_CYC - 1);
            state_q   <= ST_PGM;
          end
          ST_PGM: if (!step_end) cnt_q <= cnt_q - 1'b1;
          else if (!at_end) begin
            if (last_wrd) begin sec_q <= nxt_sec; wrd_q <= '0; end
            else wrd_q <= wrd_q + 1'b1;
            cnt_q <= CNT_W'(PGM_CYC - 1);
          end else begin
            state_q <= ST_PVFY;
            sec_q   <= first_sec;
            wrd_q   <= '0;
            cnt_q   <= CNT_W'(VFY_CYC - 1);
          end
          ST_PVFY: if (!step_end) cnt_q <= cnt_q - 1'b1;
          else if (eng_data_i != '0) begin
            state_q <= ST_PGM;  // reprogram the failing word
            cnt_q   <= CNT_W'(PGM_CYC - 1);
          end else if (!at_end) begin
            if (last_wrd) begin sec_q <= nxt_sec; wrd_q <= '0; end
            else wrd_q <= wrd_q + 1'b1;
            cnt_q <= CNT_W'(VFY_CYC - 1);
          end else begin
            state_q <= ST_ERS;
            cnt_q   <= CNT_W'(ERS_CYC - 1);
            pul_q   <= '0;
          end
          ST_ERS: if (!step_end) cnt_q <= cnt_q - 1'b1;
          else begin
            if (int'(pul_q) < ERS_PULSES) pul_q <= pul_q + 1'b1;
            state_q <= ST_EVFY;
            sec_q   <= first_sec;
            wrd_q   <= '0;
            cnt_q   <= CNT_W'(VFY_CYC - 1);
          end
          ST_EVFY: if (!step_end) cnt_q <= cnt_q - 1'b1;
          else if (eng_data_i != '1) begin
            state_q <= ST_ERS;
            cnt_q   <= CNT_W'(ERS_CYC - 1);
          end else if (!at_end) begin
            if (last_wrd) begin sec_q <= nxt_sec; wrd_q <= '0; end
            else wrd_q <= wrd_q + 1'b1;
            cnt_q <= CNT_W'(VFY_CYC - 1);
          end else begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            bad_q   <= bad_q & ~op_mask_q;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy_no    = (state_q == ST_IDLE);
  assign done_o     = done_q;
  assign erase_ph_o = (state_q == ST_ERS) || (state_q == ST_EVFY);
  assign bad_o      = bad_q;
  assign op_mask_o  = op_mask_q;
  assign eng_addr_o = {sec_q, wrd_q};
  assign pgm_we_o   = (state_q == ST_PGM) && step_end;
  // margin reached on the last required pulse
  assign ers_o      = (state_q == ST_ERS) && step_end && (int'(pul_q) + 1 >= ERS_PULSES);
endmodule

// File: rtl/fes_rdmux.sv
module fes_rdmux #(
  parameter int NUM_SECTORS = 4,
  parameter int DATA_W      = 16,
  parameter int AW          = 5,
  parameter int SEC_W       = 2,
  parameter logic [DATA_W-1:0] INV_PAT = 16'hA5A5
) (
  input  logic                   busy_ni,
  input  logic                   erase_ph_i,
  input  logic [AW-1:0]          rd_addr_i,
  input  logic [DATA_W-1:0]      arr_data_i,
  input  logic [NUM_SECTORS-1:0] bad_i,
  output logic [DATA_W-1:0]      rd_data_o,
  output logic                   rd_bad_o
);
  logic [SEC_W-1:0] rd_sec;
  logic [DATA_W-1:0] status;

  assign rd_sec = rd_addr_i[AW-1 -: SEC_W];

  always_comb begin
    status = '0;
    status[6]  = erase_ph_i;
    status[14] = erase_ph_i;
  end

  always_comb begin
    rd_bad_o  = 1'b0;
    rd_data_o = arr_data_i;
    if (!busy_ni) begin
      rd_data_o = status;
    end else if (bad_i[rd_sec]) begin
      rd_data_o = INV_PAT;
      rd_bad_o  = 1'b1;
    end
  end
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int NUM_SECTORS  = 4,
  parameter int SECTOR_WORDS = 8,
  parameter int DATA_W       = 16,
  parameter int PGM_CYC      = 3,
  parameter int VFY_CYC      = 2,
  parameter int ERS_CYC      = 5,
  parameter int ERS_PULSES   = 2,
  parameter logic [DATA_W-1:0] INV_PAT = 16'hA5A5,
  localparam int SEC_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1,
  localparam int WRD_W = (SECTOR_WORDS > 1) ? $clog2(SECTOR_WORDS) : 1,
  localparam int AW    = SEC_W + WRD_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [NUM_SECTORS-1:0] sec_mask_i,
  input  logic                   chip_i,
  input  logic                   abort_i,
  input  logic                   wr_en_i,
  input  logic [AW-1:0]          wr_addr_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  input  logic [AW-1:0]          rd_addr_i,
  output logic [DATA_W-1:0]      rd_data_o,
  output logic                   rd_bad_o,
  output logic                   busy_no,
  output logic                   done_o
);
  logic                   erase_ph, pgm_we, ers;
  logic [NUM_SECTORS-1:0] bad, op_mask;
  logic [AW-1:0]          eng_addr;
  logic [DATA_W-1:0]      eng_data, arr_data;

  fes_seq #(
    .NUM_SECTORS(NUM_SECTORS), .SECTOR_WORDS(SECTOR_WORDS), .DATA_W(DATA_W),
    .PGM_CYC(PGM_CYC), .VFY_CYC(VFY_CYC), .ERS_CYC(ERS_CYC),
    .ERS_PULSES(ERS_PULSES), .SEC_W(SEC_W), .WRD_W(WRD_W)
  ) u_seq (
    .clk_i, .rst_ni, .start_i, .sec_mask_i, .chip_i, .abort_i,
    .busy_no, .done_o,
    .erase_ph_o(erase_ph), .bad_o(bad), .pgm_we_o(pgm_we), .ers_o(ers),
    .op_mask_o(op_mask), .eng_addr_o(eng_addr), .eng_data_i(eng_data)
  );

  fes_array #(
    .NUM_SECTORS(NUM_SECTORS), .SECTOR_WORDS(SECTOR_WORDS),
    .DATA_W(DATA_W), .AW(AW)
  ) u_arr (
    .clk_i, .rst_ni,
    .host_we_i(wr_en_i && busy_no), .host_addr_i(wr_addr_i), .host_data_i(wr_data_i),
    .pgm_we_i(pgm_we), .pgm_addr_i(eng_addr),
    .ers_i(ers), .ers_mask_i(op_mask),
    .rd_addr_i(rd_addr_i), .rd_data_o(arr_data),
    .vfy_addr_i(eng_addr), .vfy_data_o(eng_data)
  );

  fes_rdmux #(
    .NUM_SECTORS(NUM_SECTORS), .DATA_W(DATA_W), .AW(AW), .SEC_W(SEC_W),
    .INV_PAT(INV_PAT)
  ) u_rd (
    .busy_ni(busy_no), .erase_ph_i(erase_ph), .rd_addr_i(rd_addr_i),
    .arr_data_i(arr_data), .bad_i(bad), .rd_data_o(rd_data_o), .rd_bad_o(rd_bad_o)
  );
endmodule

// File: rtl/fes_chk.sv
module fes_chk #(
  parameter int NUM_SECTORS = 4,
  parameter int DATA_W      = 16
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   start_i,
  input logic [NUM_SECTORS-1:0] sec_mask_i,
  input logic                   chip_i,
  input logic                   abort_i,
  input logic [DATA_W-1:0]      rd_data_o,
  input logic                   rd_bad_o,
  input logic                   busy_no,
  input logic                   done_o
);
  assert_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_no && start_i && (chip_i || |sec_mask_i) |=> !busy_no);

  assert_empty_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_no && start_i && !chip_i && sec_mask_i == '0 |=> busy_no);

  assert_status_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_no |-> !rd_data_o[7] && !rd_data_o[15] && !rd_bad_o);

  assert_done_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $rose(busy_no));

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_abort_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_no && abort_i |=> busy_no && !done_o);

  assert_idle_abort_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_no && abort_i && !start_i |=> busy_no);
endmodule

bind flash_erase_seq fes_chk #(.NUM_SECTORS(NUM_SECTORS), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .sec_mask_i(sec_mask_i),
  .chip_i(chip_i), .abort_i(abort_i), .rd_data_o(rd_data_o), .rd_bad_o(rd_bad_o),
  .busy_no(busy_no), .done_o(done_o)
);

// File: tb/sim_flash_erase_seq.sv
`timescale 1ns/1ps
module sim_flash_erase_seq;
  localparam int NS = 4, SW = 8, PGM = 3, VFY = 2, ERS = 5, PUL = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, chip_i = 0, abort_i = 0, wr_en_i = 0;
  logic [NS-1:0] sec_mask_i = '0;
  logic [4:0] wr_addr_i = '0, rd_addr_i = '0;
  logic [15:0] wr_data_i = '0, rd_data_o;
  logic rd_bad_o, busy_no, done_o;
  int n_chk = 0, n_fail = 0;

  always #4 clk_i = ~clk_i;

  flash_erase_seq #(.NUM_SECTORS(NS), .SECTOR_WORDS(SW), .DATA_W(16),
    .PGM_CYC(PGM), .VFY_CYC(VFY), .ERS_CYC(ERS), .ERS_PULSES(PUL)) u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d, output logic b);
    rd_addr_i = a; #1; d = rd_data_o; b = rd_bad_o;
  endtask

  task automatic chk_word(input logic [4:0] a, input logic [15:0] exp, input logic expb, input string req);
    logic [15:0] d; logic b;
    rd(a, d, b);
    chk(d == exp && b == expb, req, {15'd0, b, d}, {15'd0, expb, exp});
  endtask

  task automatic host_wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk_i); wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i); wr_en_i = 0;
  endtask

  function automatic int t_expect(input int n);
    return n * PGM + 2 * n * VFY + PUL * ERS + (PUL - 1) * VFY;
  endfunction

  // runs an erase to completion; probes status, a busy write and a busy restart
  task automatic run_erase(input logic [NS-1:0] m, input logic ch, input logic [4:0] probe, input string tag);
    int n, k, sw_pt;
    logic [15:0] d; logic b;
    n = (ch ? NS : $countones(m)) * SW;
    sw_pt = n * (PGM + VFY);
    k = 0;
    @(negedge clk_i); start_i = 1; sec_mask_i = m; chip_i = ch;
    @(negedge clk_i); start_i = 0; chip_i = 0;
    forever begin
      if (busy_no || k > 2000) break;
      k++;
      if (k == 2) begin
        rd(probe, d, b);
        chk(!d[7] && !d[15] && !b, {tag, " R4 busy status"}, {15'd0, b, d}, 32'h0);
      end
      if (k == 4) begin start_i = 1; sec_mask_i = '1; end
      if (k == 5) begin start_i = 0; wr_en_i = 1; wr_addr_i = probe; wr_data_i = 16'h0; end
      if (k == 6) wr_en_i = 0;
      if (k == sw_pt) begin rd(probe, d, b); chk(d[6] == 0 && d[14] == 0, {tag, " R2 pre-program phase"}, d, 32'h0); end
      if (k == sw_pt + 1) begin rd(probe, d, b); chk(d[6] && d[14], {tag, " R2 erase phase"}, d, 32'h4040); end
      @(negedge clk_i);
    end
    chk(k == t_expect(n), {tag, " R3 busy length"}, k, t_expect(n));
    chk(done_o == 1, {tag, " R6 done with ready"}, done_o, 1);
    @(negedge clk_i);
    chk(done_o == 0, {tag, " R6 done single cycle"}, done_o, 0);
  endtask

  task automatic t_reset;
    chk(busy_no == 1 && done_o == 0, "R1 reset idle", {busy_no, done_o}, 2'b10);
    chk_word(5'd0, 16'hFFFF, 0, "R5 reset array ones");
  endtask

  task automatic t_program;
    host_wr(5'd3, 16'h1234);
    chk_word(5'd3, 16'h1234, 0, "R9 write");
    host_wr(5'd3, 16'hFF00);
    chk_word(5'd3, 16'h1200, 0, "R9 write clears only");
  endtask

  task automatic t_one_sector;
    host_wr(5'd8, 16'h0F0F);
    host_wr(5'd17, 16'h5A5A);
    run_erase(4'b0010, 0, 5'd17, "sec1");
    chk_word(5'd8, 16'hFFFF, 0, "R5 erased first word");
    chk_word(5'd15, 16'hFFFF, 0, "R5 erased last word");
    chk_word(5'd17, 16'h5A5A, 0, "R9 busy write ignored / R5 other sector kept");
    chk_word(5'd3, 16'h1200, 0, "R5 sector0 kept");
  endtask

  task automatic t_two_sectors;
    run_erase(4'b0101, 0, 5'd9, "sec0+2");
    chk_word(5'd3, 16'h1200 | 16'hEDFF, 0, "R5 sector0 erased");
    chk_word(5'd17, 16'hFFFF, 0, "R5 sector2 erased");
  endtask

  task automatic t_empty_start;
    @(negedge clk_i); start_i = 1; sec_mask_i = '0; chip_i = 0;
    @(negedge clk_i); start_i = 0;
    chk(busy_no == 1, "R1 empty mask ignored", busy_no, 1);
    @(negedge clk_i);
    chk(busy_no == 1 && done_o == 0, "R1 empty mask stays idle", {busy_no, done_o}, 2'b10);
  endtask

  task automatic t_chip;
    host_wr(5'd20, 16'h0000);
    host_wr(5'd31, 16'h00F0);
    run_erase(4'b0000, 1, 5'd0, "chip");
    chk_word(5'd20, 16'hFFFF, 0, "R10 chip erase sector2");
    chk_word(5'd31, 16'hFFFF, 0, "R10 chip erase sector3");
  endtask

  task automatic t_abort;
    host_wr(5'd2, 16'h00AA);
    @(negedge clk_i); start_i = 1; sec_mask_i = 4'b1000;
    @(negedge clk_i); start_i = 0;
    repeat (10) @(negedge clk_i);
    chk(busy_no == 0, "R7 running before abort", busy_no, 0);
    abort_i = 1;
    @(negedge clk_i); abort_i = 0;
    chk(busy_no == 1 && done_o == 0, "R7 abort stops", {busy_no, done_o}, 2'b10);
    chk_word(5'd24, 16'hA5A5, 1, "R7 invalid sector first word");
    chk_word(5'd30, 16'hA5A5, 1, "R7 invalid sector word6");
    chk_word(5'd2, 16'h00AA, 0, "R7 other sector normal");
  endtask

  task automatic t_idle_abort;
    @(negedge clk_i); abort_i = 1;
    @(negedge clk_i); abort_i = 0;
    chk(busy_no == 1, "R11 idle abort busy", busy_no, 1);
    chk_word(5'd2, 16'h00AA, 0, "R11 idle abort data");
    chk_word(5'd24, 16'hA5A5, 1, "R11 idle abort keeps flag");
  endtask

  task automatic t_recover;
    run_erase(4'b1000, 0, 5'd24, "recover");
    chk_word(5'd24, 16'hFFFF, 0, "R8 flag cleared");
    chk_word(5'd31, 16'hFFFF, 0, "R8 sector erased");
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_program();
    t_one_sector();
    t_two_sectors();
    t_empty_start();
    t_chip();
    t_abort();
    t_idle_abort();
    t_recover();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule